// File: doc/BRIEF.md
# Two-Way Cache Tag and Policy Controller

This block holds the tags, valid bits, dirty bits and replacement state of a small two-way set-associative cache. A client presents a byte address with a read or write strobe. The controller looks up both ways of the indexed set at the same time. It then reports hit or miss and, when the access needs the next level, issues the memory operations one after another over a request/acknowledge port. The data array is kept elsewhere and follows the fill and writeback requests this block issues.

Three policies are sampled from input pins when each request is accepted:
- write-back or write-through for writes;
- allocate or no-allocate for write misses;
- least-recently-used, FIFO round-robin or pseudo-random choice of the way to replace.

While memory operations are outstanding the controller holds `busy` high and accepts no new request. It completes each request with a one-cycle response pulse.

Top module: `cache_ctrl`

## Requirements
- R1: The address splits into offset (low log2(BLOCK_BYTES) bits), index (next log2(SETS) bits) and tag (remaining upper bits). With the defaults these are bits [2:0], [4:3] and [7:5]. A request hits when a valid way of the indexed set holds its tag, and `resp_hit` reports this with the response pulse.
- R2: A read hit, or a write hit in write-back mode, completes with `resp_valid` high for one cycle in the cycle after acceptance. It issues no memory operation and leaves `busy` low.
- R3: A read miss always allocates. It issues a fill (`mem_write`=0) at the block-aligned address, and later reads to the block hit.
- R4: A write miss with allocate selected (`wr_alloc`=1) fills the block. In write-back mode the new line is then dirty.
- R5: A write miss with no-allocate selected issues one memory write at the full byte address and installs nothing, so a following read of that block misses.
- R6: In write-back mode (`wb_mode`=1) a write hit marks the line dirty. Replacing a dirty line first issues a memory write at {victim tag, index, zero offset}, and the fill follows it.
- R7: In write-through mode every write issues a memory write at the full byte address. On an allocating miss this write comes after the fill. Such writes leave lines clean, so replacing the line later issues no writeback.
- R8: On a miss that allocates, an invalid way is filled before any valid way is evicted, with way 0 taking priority over way 1.
- R9: With `repl_sel`=0 (and also 3), the way replaced is the one not most recently hit or filled in that set.
- R10: With `repl_sel`=1, each set keeps a round-robin pointer that moves to the other way only when a fill happens. Hits do not move it.
- R11: With `repl_sel`=2, the victim is bit 0 of an 8-bit LFSR taken before it advances. The LFSR resets to 8'h01 and advances on every miss as next = {q[6:0], q[7]^q[5]^q[4]^q[3]}.
- R12: `busy` and `mem_req` stay high from acceptance until the final `mem_ack`. Address and direction hold steady until each acknowledge.
- R13: After reset all lines are invalid and `busy`, `mem_req` and `resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through |
| wr_alloc | input | 1 | 1 = allocate on write miss |
| repl_sel | input | 2 | 0 LRU, 1 FIFO, 2 random, 3 LRU |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Lookup result of the completed request |
| busy | output | 1 | Memory operations outstanding |
| mem_req | output | 1 | Next-level operation request |
| mem_write | output | 1 | 1 = writeback or forwarded write, 0 = fill |
| mem_addr | output | ADDR_W | Next-level address |
| mem_ack | input | 1 | Next-level acknowledge, one cycle |

## Verification
The assertions take two things for granted. First, the client raises `req_valid` only while `busy` is low. Second, the next level pulses `mem_ack` for a single cycle and only while `mem_req` is high. The bench drives requests one at a time and waits for each response before the next. Its memory model acknowledges after a short random delay, drops `mem_ack` in the following cycle and never acknowledges an idle port. Under these rules no two tags in a set match and the response ordering is well defined.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2,
        ST_WT   = 2'd3
    } cc_state_e;

    typedef enum logic [1:0] {
        RP_LRU  = 2'd0,
        RP_FIFO = 2'd1,
        RP_RAND = 2'd2,
        RP_ALT  = 2'd3
    } cc_repl_e;
endpackage

// File: rtl/cc_lfsr.sv
module cc_lfsr #(
    parameter int          W        = 8,
    parameter logic [W-1:0] TAP_MASK = 8'hB8,
    parameter logic [W-1:0] SEED     = 8'h01
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic pick
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (adv) lfsr_d = {lfsr_q[W-2:0], ^(lfsr_q & TAP_MASK)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign pick = lfsr_q[0];

    assert_lfsr_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
    assert_lfsr_steps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(lfsr_q));
endmodule

// File: rtl/cc_victim.sv
module cc_victim
    import cache_pkg::*;
(
    input  logic [WAYS-1:0] vld,
    input  logic            lru_way,
    input  logic            fifo_way,
    input  logic            rnd_way,
    input  cc_repl_e        sel,
    output logic            way
);
    always_comb begin
        if (!vld[0])      way = 1'b0;
        else if (!vld[1]) way = 1'b1;
        else begin
            unique case (sel)
                RP_FIFO: way = fifo_way;
                RP_RAND: way = rnd_way;
                default: way = lru_way;
            endcase
        end
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BLOCK_BYTES = 8,
    parameter int SETS        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wb_mode,
    input  logic              wr_alloc,
    input  logic [1:0]        repl_sel,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    typedef struct packed {
        cc_state_e                              st;
        logic [SETS-1:0][WAYS-1:0]              vld;
        logic [SETS-1:0][WAYS-1:0]              drt;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag;
        logic [SETS-1:0]                        lru;
        logic [SETS-1:0]                        fifo;
        logic [IDX_W-1:0]                       idx;
        logic [TAG_W-1:0]                       tg;
        logic [OFF_W-1:0]                       off;
        logic                                   wr;
        logic                                   wb;
        logic                                   way;
        logic [TAG_W-1:0]                       vtag;
        logic                                   hit;
        logic                                   rsp;
    } cc_regs_t;

    cc_regs_t r_q, r_d;

    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    assign req_off = req_addr[OFF_W-1:0];
    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

    logic [WAYS-1:0] hit_vec;
    logic            hit_any, hit_way;
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = r_q.vld[req_idx][w] && (r_q.tag[req_idx][w] == req_tag);
    end
    assign hit_any = |hit_vec;
    assign hit_way = hit_vec[1];

    logic accept, miss_adv, rnd_way, vic_way;
    assign accept   = req_valid && (r_q.st == ST_IDLE);
    assign miss_adv = accept && !hit_any;

    cc_lfsr #(.W(8), .TAP_MASK(8'hB8), .SEED(8'h01)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (miss_adv),
        .pick (rnd_way)
    );

    cc_victim u_victim (
        .vld     (r_q.vld[req_idx]),
        .lru_way (r_q.lru[req_idx]),
        .fifo_way(r_q.fifo[req_idx]),
        .rnd_way (rnd_way),
        .sel     (cc_repl_e'(repl_sel)),
        .way     (vic_way)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rsp = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.idx = req_idx;
                    r_d.tg  = req_tag;
                    r_d.off = req_off;
                    r_d.wr  = req_write;
                    r_d.wb  = wb_mode;
                    r_d.hit = hit_any;
                    if (hit_any) begin
                        r_d.way = hit_way;
                        r_d.lru[req_idx] = ~hit_way;
                        if (req_write && wb_mode) r_d.drt[req_idx][hit_way] = 1'b1;
                        if (req_write && !wb_mode) r_d.st = ST_WT;
                        else                       r_d.rsp = 1'b1;
                    end else if (!req_write || wr_alloc) begin
                        r_d.way  = vic_way;
                        r_d.vtag = r_q.tag[req_idx][vic_way];
                        if (r_q.vld[req_idx][vic_way] && r_q.drt[req_idx][vic_way])
                            r_d.st = ST_WB;
                        else
                            r_d.st = ST_FILL;
                    end else begin
                        r_d.st = ST_WT;
                    end
                end
            end
            ST_WB: begin
                if (mem_ack) r_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack) begin
                    r_d.vld[r_q.idx][r_q.way] = 1'b1;
                    r_d.tag[r_q.idx][r_q.way] = r_q.tg;
                    r_d.drt[r_q.idx][r_q.way] = r_q.wr && r_q.wb;
                    r_d.lru[r_q.idx]          = ~r_q.way;
                    r_d.fifo[r_q.idx]         = ~r_q.way;
                    if (r_q.wr && !r_q.wb) begin
                        r_d.st = ST_WT;
                    end else begin
                        r_d.st  = ST_IDLE;
                        r_d.rsp = 1'b1;
                    end
                end
            end
            ST_WT: begin
                if (mem_ack) begin
                    r_d.st  = ST_IDLE;
                    r_d.rsp = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign resp_valid = r_q.rsp;
    assign resp_hit   = r_q.hit;
    assign busy       = (r_q.st != ST_IDLE);
    assign mem_req    = busy;
    assign mem_write  = (r_q.st == ST_WB) || (r_q.st == ST_WT);

    always_comb begin
        unique case (r_q.st)
            ST_WB:   mem_addr = {r_q.vtag, r_q.idx, {OFF_W{1'b0}}};
            ST_WT:   mem_addr = {r_q.tg, r_q.idx, r_q.off};
            default: mem_addr = {r_q.tg, r_q.idx, {OFF_W{1'b0}}};
        endcase
    end

    assert_single_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit_vec) <= 1);
    assert_quick_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_any && !(req_write && !wb_mode)) |=> (!busy && resp_valid));
    assert_fill_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_write) |-> (mem_addr[OFF_W-1:0] == '0));
    assert_wb_before_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WB && mem_ack) |=> (mem_req && !mem_write));
    assert_wt_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && !wb_mode) |=> $stable(r_q.drt));
    assert_ack_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |-> mem_req);
    assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));
    assert_no_req_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !busy);
endmodule

// File: tb/sim_cache_ctrl.sv
module sim_cache_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic       wb_mode = 1'b1, wr_alloc = 1'b1;
    logic [1:0] repl_sel = 2'd0;
    logic       resp_valid, resp_hit, busy, mem_req, mem_write, mem_ack = 1'b0;
    logic [7:0] mem_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .wb_mode(wb_mode), .wr_alloc(wr_alloc), .repl_sel(repl_sel),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .busy(busy), .mem_req(mem_req),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_ack(mem_ack)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    int mv[4][2], md[4][2], mt[4][2], mlru[4], mfifo[4];
    int lf = 1;
    int op_q[$];
    string cur_tag = "R1";

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Next-level memory: random delay, one-cycle ack, checks each operation
    initial begin
        int cnt = 0;
        int dly = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (cnt >= dly) begin
                    int got;
                    got = (mem_write ? 256 : 0) + int'(mem_addr);
                    if (op_q.size() == 0) chk(0, {cur_tag, " unexpected mem op"}, got, -1);
                    else begin
                        int e;
                        e = op_q.pop_front();
                        chk(got == e, {cur_tag, " mem op (write*256+addr)"}, got, e);
                    end
                    mem_ack = 1'b1;
                    cnt = 0;
                    dly = int'($urandom_range(0, 2));
                end else cnt++;
            end
        end
    end

    // Behavioural reference: predicts hit and the ordered memory operations
    task automatic predict(input bit w, input int a, output bit hit);
        int i, tg, hw, way, pre;
        i = (a / 8) % 4;
        tg = a / 32;
        hit = 0; hw = 0;
        for (int k = 0; k < 2; k++)
            if (mv[i][k] != 0 && mt[i][k] == tg) begin hit = 1; hw = k; end
        if (hit) begin
            mlru[i] = 1 - hw;
            if (w && wb_mode) md[i][hw] = 1;
            if (w && !wb_mode) op_q.push_back(256 + a);
        end else begin
            pre = lf;
            lf = ((lf << 1) & 255) | (((lf >> 7) ^ (lf >> 5) ^ (lf >> 4) ^ (lf >> 3)) & 1);
            if (!w || wr_alloc) begin
                if (mv[i][0] == 0) way = 0;
                else if (mv[i][1] == 0) way = 1;
                else if (repl_sel == 2'd1) way = mfifo[i];
                else if (repl_sel == 2'd2) way = pre & 1;
                else way = mlru[i];
                if (mv[i][way] != 0 && md[i][way] != 0) op_q.push_back(256 + mt[i][way] * 32 + i * 8);
                op_q.push_back(tg * 32 + i * 8);
                mv[i][way] = 1; mt[i][way] = tg;
                md[i][way] = (w && wb_mode) ? 1 : 0;
                mlru[i] = 1 - way; mfifo[i] = 1 - way;
                if (w && !wb_mode) op_q.push_back(256 + a);
            end else begin
                op_q.push_back(256 + a);
            end
        end
    endtask

    task automatic issue(input bit w, input int a, input string tag);
        bit eh, has_mem;
        int guard = 0;
        cur_tag = tag;
        predict(w, a, eh);
        has_mem = (op_q.size() != 0);
        req_valid = 1'b1; req_write = w; req_addr = a[7:0];
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid == !has_mem, {tag, " resp timing"}, int'(resp_valid), int'(!has_mem));
        chk(busy == has_mem, {tag, " busy after accept"}, int'(busy), int'(has_mem));
        while (!resp_valid && guard < 100) begin
            chk(busy == 1'b1, {tag, " busy held (R12)"}, int'(busy), 1);
            @(negedge clk);
            guard++;
        end
        chk(resp_valid == 1'b1, {tag, " response arrives"}, int'(resp_valid), 1);
        chk(resp_hit == eh, {tag, " hit (R1)"}, int'(resp_hit), int'(eh));
        chk(op_q.size() == 0, {tag, " all mem ops issued"}, op_q.size(), 0);
        chk(busy == 1'b0, {tag, " idle at response"}, int'(busy), 0);
    endtask

    initial begin
        for (int s = 0; s < 4; s++) begin
            mlru[s] = 0; mfifo[s] = 0;
            for (int k = 0; k < 2; k++) begin mv[s][k] = 0; md[s][k] = 0; mt[s][k] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !resp_valid, "R13 reset outputs", int'({busy, mem_req, resp_valid}), 0);

        // R3 read miss allocates, R2 quick read hit
        wb_mode = 1; wr_alloc = 1; repl_sel = 0;
        issue(0, 4, "R3");
        issue(0, 7, "R2");
        issue(0, 16, "R13");
        // R6 write-back hit dirties line
        issue(1, 4, "R6");
        // R8 invalid way first
        issue(0, 132, "R8");
        issue(0, 4, "R9");
        // R9 LRU evicts way 1 (clean), then way 0 (dirty -> writeback, R6)
        issue(0, 68, "R9");
        issue(0, 132, "R6");
        // R10 FIFO on set 1
        repl_sel = 1;
        issue(0, 8, "R10");
        issue(0, 40, "R10");
        issue(0, 8, "R10");
        issue(0, 72, "R10");
        issue(0, 40, "R10");
        issue(0, 8, "R10");
        // R11 random on set 2
        repl_sel = 2;
        issue(0, 48, "R11");
        issue(0, 80, "R11");
        issue(0, 112, "R11");
        issue(0, 144, "R11");
        issue(0, 176, "R11");
        // R5 write-through no-allocate miss
        wb_mode = 0; wr_alloc = 0; repl_sel = 0;
        issue(1, 29, "R5");
        issue(0, 29, "R5");
        // R7 write-through hit and allocating miss, then evictions without writeback
        issue(1, 26, "R7");
        wr_alloc = 1;
        issue(1, 59, "R7");
        issue(0, 91, "R7");
        issue(0, 123, "R7");
        // R4 write-back allocate
        wb_mode = 1;
        issue(1, 221, "R4");
        issue(0, 253, "R4");
        issue(0, 189, "R4");
        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            wb_mode = 1'($urandom_range(0, 1));
            wr_alloc = 1'($urandom_range(0, 1));
            repl_sel = 2'($urandom_range(0, 3));
            issue(1'($urandom_range(0, 1)), int'($urandom_range(0, 255)), "R1");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog R12 act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule